// File: doc/BRIEF.md
# Shared-Comparator Deadline Multiplexer

Several clients, for example the cores of one node, may each have one one-shot deadline pending. All of them use one free-running 64-bit tick counter and one hardware compare register. The block keeps one deadline slot per client. It also records which client currently owns the comparator, and it keeps the comparator loaded with the earliest pending deadline. When the counter reaches that deadline, the owning client alone receives a one-cycle event. Every other client receives nothing.

Requests arrive one at a time over a valid/ready port. A request either sets a deadline or cancels one, and a cancel may be forced. Each request gets one response that names the client and carries a result code. When the comparator must be reloaded, the block always walks the same safe sequence:

1. Mask the compare.
2. Park the comparator at all-ones.
3. Clear the sticky pending flag.
4. Unmask the compare.
5. Load the new value.

After the load the block checks whether the counter had already passed the deadline. A requester whose deadline was already behind the counter gets a "missed" status, and its slot is freed. When an owner's slot is freed, the block scans all slots sequentially for the next-earliest one. If the deadline of the newly chosen owner has already passed, the block fires that owner's event immediately.

Top module: `shared_cmp_timer_mux`

## Requirements
- R1: After reset every slot is idle (all-ones), no client owns the comparator, the compare is masked, `req_ready_o` is high, and no event or response is driven.
- R2: A set (op 0) always stores the deadline, and answers code 0 (set accepted) unless it misses. It reloads the comparator only in three cases: no client owns it, the requester already owns it, or the new deadline is strictly below the owner's deadline. In every other case the current owner stays in charge.
- R3: The comparator is reloaded in a fixed order: mask, load all-ones, clear the pending flag, unmask, load the deadline. The pending flag is cleared only while the compare is masked and parked at all-ones.
- R4: If, after a requester's own reload, the counter is strictly above the deadline and no compare is pending, the set answers code 1 (missed). The slot then returns to all-ones and the next-earliest pending deadline is loaded.
- R5: The next-owner scan picks the lowest deadline strictly below all-ones. On a tie, the lower client index wins.
- R6: A scan that finds no pending slot leaves no owner and keeps the compare masked, so no event follows.
- R7: If the reload for a scan-chosen owner finds its deadline already passed, that client's event fires at once.
- R8: A non-forced cancel (op 1, force 0) answers code 2 (done) only if the requester is the owner and the counter is at or above its deadline; otherwise it answers code 3 (refused). A forced cancel always answers code 2.
- R9: A successful cancel sets the slot to all-ones. A scan follows only if the canceller was the owner; a cancelled non-owner never receives an event.
- R10: When the counter is at or above the loaded deadline, the owner receives exactly one single-cycle pulse on its bit of `evt_o`, and no other bit is raised.
- R11: While a scan or a reload runs, `req_ready_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_count_i | input | CNT_W | Shared free-running counter value |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can take a request |
| req_op_i | input | 1 | 0 = set deadline, 1 = cancel |
| req_force_i | input | 1 | Cancel unconditionally |
| req_client_i | input | IDX_W | Requesting client index |
| req_deadline_i | input | CNT_W | Absolute deadline for a set |
| resp_valid_o | output | 1 | Response pulse |
| resp_client_o | output | IDX_W | Client the response belongs to |
| resp_code_o | output | 2 | 0 set ok, 1 set missed, 2 cancel done, 3 cancel refused |
| evt_o | output | N | One-cycle deadline event per client |

## Verification
The hardest case to reach is a scan-chosen owner whose deadline has already passed, because the counter never stops while that owner is being chosen. The bench gives two clients the same deadline. The tie leaves the lower-index client as owner and the second one waiting. The bench then waits for the owner's event and cancels it. The scan now picks the waiting client, whose deadline lies in the past, and its event must fire at once. A second construction makes an already-past set undercut a live owner. That set must report a miss and hand the comparator back to the earlier owner.

// File: rtl/tmux_pkg.sv
package tmux_pkg;

    localparam logic OP_SET    = 1'b0;
    localparam logic OP_CANCEL = 1'b1;

    typedef enum logic [1:0] {
        RSP_SET_OK      = 2'd0,
        RSP_SET_MISSED  = 2'd1,
        RSP_CXL_DONE    = 2'd2,
        RSP_CXL_REFUSED = 2'd3
    } rsp_code_e;

    typedef enum logic [2:0] {
        CMP_NOP,
        CMP_MASK,
        CMP_LOAD_MAX,
        CMP_CLEAR,
        CMP_UNMASK,
        CMP_LOAD
    } cmp_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_MASK,
        ST_CMAX,
        ST_CLR,
        ST_CFG,
        ST_LOAD,
        ST_CHECK
    } mux_state_e;

endpackage

// File: rtl/tmux_cmp_unit.sv
module tmux_cmp_unit
    import tmux_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  cmp_cmd_e         cmd_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             mask_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             pend_o
);
    logic             mask_q;
    logic [CNT_W-1:0] cmp_q;
    logic             pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= 1'b1;
            cmp_q  <= '1;
            pend_q <= 1'b0;
        end else begin
            case (cmd_i)
                CMP_MASK:     mask_q <= 1'b1;
                CMP_LOAD_MAX: cmp_q  <= '1;
                CMP_UNMASK:   mask_q <= 1'b0;
                CMP_LOAD:     cmp_q  <= load_val_i;
                default:      ;
            endcase
            if (cmd_i == CMP_CLEAR)
                pend_q <= 1'b0;
            else if (!mask_q && count_i >= cmp_q)
                pend_q <= 1'b1;
        end
    end

    assign mask_o = mask_q;
    assign cmp_o  = cmp_q;
    assign pend_o = pend_q;

    AST_CLR_PARKED: assert property (@(posedge clk) disable iff (rst)
        cmd_i == CMP_CLEAR |-> mask_q && (cmp_q == '1)); // R3
    AST_LOAD_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        cmd_i == CMP_LOAD |-> !mask_q); // R3
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        pend_q && cmd_i != CMP_CLEAR |=> pend_q); // R10

endmodule

// File: rtl/tmux_min_scan.sv
module tmux_min_scan #(
    parameter int N     = 4,
    parameter int CNT_W = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [N-1:0][CNT_W-1:0]   slots_i,
    output logic                      done_o,
    output logic                      found_o,
    output logic [$clog2(N)-1:0]      idx_o,
    output logic [CNT_W-1:0]          val_o
);
    localparam int IDX_W = $clog2(N);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic             busy_q;
    logic             done_q;
    logic [IDX_W-1:0] pos_q;
    logic [IDX_W-1:0] bidx_q;
    logic [CNT_W-1:0] best_q;
    logic             take;

    // strict compare: an equal later slot never displaces an earlier one
    assign take = slots_i[pos_q] < best_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            pos_q  <= '0;
            bidx_q <= '0;
            best_q <= '1;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                busy_q <= 1'b1;
                pos_q  <= '0;
                bidx_q <= '0;
                best_q <= '1;
            end else if (busy_q) begin
                if (take) begin
                    best_q <= slots_i[pos_q];
                    bidx_q <= pos_q;
                end
                if (pos_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end

    assign done_o  = done_q;
    assign found_o = (best_q != '1);
    assign idx_o   = bidx_q;
    assign val_o   = best_q;

    AST_SCAN_PICK_MATCHES: assert property (@(posedge clk) disable iff (rst)
        done_q && found_o |-> slots_i[bidx_q] == best_q); // R5

endmodule

// File: rtl/shared_cmp_timer_mux.sv
module shared_cmp_timer_mux
    import tmux_pkg::*;
#(
    parameter int N     = 4,
    parameter int CNT_W = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tick_count_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic             req_op_i,
    input  logic             req_force_i,
    input  logic [IDX_W-1:0] req_client_i,
    input  logic [CNT_W-1:0] req_deadline_i,
    output logic             resp_valid_o,
    output logic [IDX_W-1:0] resp_client_o,
    output logic [1:0]       resp_code_o,
    output logic [N-1:0]     evt_o
);
    mux_state_e            state_q;
    logic [N-1:0][CNT_W-1:0] slot_q;
    logic                  owner_vld_q;
    logic [IDX_W-1:0]      owner_q;
    logic [IDX_W-1:0]      req_cl_q;
    logic [CNT_W-1:0]      prog_q;
    logic                  from_scan_q;
    logic                  delivered_q;
    logic                  scan_start_q;
    logic                  resp_valid_q;
    logic [IDX_W-1:0]      resp_client_q;
    rsp_code_e             resp_code_q;
    logic [N-1:0]          evt_q;

    cmp_cmd_e              cmp_cmd;
    logic                  cmp_mask, cmp_pend;
    logic [CNT_W-1:0]      cmp_val;
    logic                  scan_done, scan_found;
    logic [IDX_W-1:0]      scan_idx;
    logic [CNT_W-1:0]      scan_val;
    logic                  late;

    tmux_cmp_unit #(.CNT_W(CNT_W)) cmp_i (
        .clk(clk), .rst(rst), .cmd_i(cmp_cmd), .load_val_i(prog_q),
        .count_i(tick_count_i), .mask_o(cmp_mask), .cmp_o(cmp_val), .pend_o(cmp_pend)
    );

    tmux_min_scan #(.N(N), .CNT_W(CNT_W)) scan_i (
        .clk(clk), .rst(rst), .start_i(scan_start_q), .slots_i(slot_q),
        .done_o(scan_done), .found_o(scan_found), .idx_o(scan_idx), .val_o(scan_val)
    );

    always_comb begin
        cmp_cmd = CMP_NOP;
        case (state_q)
            ST_MASK:  cmp_cmd = CMP_MASK;
            ST_CMAX:  cmp_cmd = CMP_LOAD_MAX;
            ST_CLR:   cmp_cmd = CMP_CLEAR;
            ST_CFG:   cmp_cmd = CMP_UNMASK;
            ST_LOAD:  cmp_cmd = CMP_LOAD;
            ST_SCAN:  if (scan_done && !scan_found) cmp_cmd = CMP_MASK;
            default:  ;
        endcase
    end

    // deadline already behind the counter with no compare recorded
    assign late = (tick_count_i > prog_q) && !cmp_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            slot_q        <= '1;
            owner_vld_q   <= 1'b0;
            owner_q       <= '0;
            req_cl_q      <= '0;
            prog_q        <= '1;
            from_scan_q   <= 1'b0;
            delivered_q   <= 1'b0;
            scan_start_q  <= 1'b0;
            resp_valid_q  <= 1'b0;
            resp_client_q <= '0;
            resp_code_q   <= RSP_SET_OK;
            evt_q         <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            scan_start_q <= 1'b0;
            evt_q        <= '0;
            case (state_q)
                ST_IDLE: begin
                    if (owner_vld_q && cmp_pend && !delivered_q) begin
                        evt_q       <= N'(1) << owner_q;
                        delivered_q <= 1'b1;
                    end
                    if (req_valid_i) begin
                        req_cl_q      <= req_client_i;
                        resp_client_q <= req_client_i;
                        if (req_op_i == OP_SET) begin
                            slot_q[req_client_i] <= req_deadline_i;
                            if (!owner_vld_q || owner_q == req_client_i ||
                                req_deadline_i < slot_q[owner_q]) begin
                                owner_q     <= req_client_i;
                                owner_vld_q <= 1'b1;
                                prog_q      <= req_deadline_i;
                                from_scan_q <= 1'b0;
                                state_q     <= ST_MASK;
                            end else begin
                                resp_valid_q <= 1'b1;
                                resp_code_q  <= RSP_SET_OK;
                            end
                        end else begin
                            resp_valid_q <= 1'b1;
                            if (req_force_i || (owner_vld_q && owner_q == req_client_i &&
                                                tick_count_i >= slot_q[req_client_i])) begin
                                slot_q[req_client_i] <= '1;
                                resp_code_q <= RSP_CXL_DONE;
                                if (owner_vld_q && owner_q == req_client_i) begin
                                    scan_start_q <= 1'b1;
                                    state_q      <= ST_SCAN;
                                end
                            end else begin
                                resp_code_q <= RSP_CXL_REFUSED;
                            end
                        end
                    end
                end
                ST_SCAN: if (scan_done) begin
                    if (scan_found) begin
                        owner_q     <= scan_idx;
                        owner_vld_q <= 1'b1;
                        prog_q      <= scan_val;
                        from_scan_q <= 1'b1;
                        state_q     <= ST_MASK;
                    end else begin
                        owner_vld_q <= 1'b0;
                        state_q     <= ST_IDLE;
                    end
                end
                ST_MASK: state_q <= ST_CMAX;
                ST_CMAX: state_q <= ST_CLR;
                ST_CLR: begin
                    delivered_q <= 1'b0;
                    state_q     <= ST_CFG;
                end
                ST_CFG:  state_q <= ST_LOAD;
                ST_LOAD: state_q <= ST_CHECK;
                ST_CHECK: begin
                    state_q <= ST_IDLE;
                    if (!from_scan_q) begin
                        resp_valid_q  <= 1'b1;
                        resp_client_q <= req_cl_q;
                        resp_code_q   <= late ? RSP_SET_MISSED : RSP_SET_OK;
                        if (late) begin
                            slot_q[req_cl_q] <= '1;
                            scan_start_q     <= 1'b1;
                            state_q          <= ST_SCAN;
                        end
                    end else if (late) begin
                        evt_q       <= N'(1) << owner_q;
                        delivered_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready_o   = (state_q == ST_IDLE);
    assign resp_valid_o  = resp_valid_q;
    assign resp_client_o = resp_client_q;
    assign resp_code_o   = resp_code_q;
    assign evt_o         = evt_q;

    AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_q)); // R10
    AST_EVT_TO_OWNER: assert property (@(posedge clk) disable iff (rst)
        (|evt_q) |-> $past(owner_vld_q) && (evt_q == (N'(1) << $past(owner_q)))); // R10
    AST_EMPTY_MASKED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !owner_vld_q) |-> cmp_mask); // R6
    AST_MISS_FREES_SLOT: assert property (@(posedge clk) disable iff (rst)
        (resp_valid_q && resp_code_q == RSP_SET_MISSED) |-> slot_q[resp_client_q] == '1); // R4
    AST_LOADED_IS_PROG: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_CHECK |-> cmp_val == prog_q); // R3

endmodule

// File: tb/shared_cmp_timer_mux_tb.sv
module shared_cmp_timer_mux_tb_top;
    localparam int N = 4;
    localparam int CNT_W = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] now_q = 64'd10000;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_op = 1'b0;
    logic             req_force = 1'b0;
    logic [1:0]       req_client = '0;
    logic [CNT_W-1:0] req_deadline = '0;
    logic             resp_valid;
    logic [1:0]       resp_client;
    logic [1:0]       resp_code;
    logic [N-1:0]     evt;

    typedef struct {
        int    cl;
        int    code;
        string tag;
    } rsp_item_t;

    rsp_item_t   rsp_q[$];
    int          evt_exp_q[$];
    int unsigned compared = 0, mismatched = 0;
    int unsigned rsp_pushed = 0, rsp_seen = 0, evt_pushed = 0, evt_seen = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) now_q <= now_q + 64'd1;

    shared_cmp_timer_mux #(.N(N), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .tick_count_i(now_q),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
        .req_force_i(req_force), .req_client_i(req_client), .req_deadline_i(req_deadline),
        .resp_valid_o(resp_valid), .resp_client_o(resp_client), .resp_code_o(resp_code),
        .evt_o(evt)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
        end
    endtask

    // monitor: pops scoreboard entries as the design produces results
    always @(negedge clk) begin
        if (!rst) begin
            if (resp_valid) begin
                if (rsp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected response", {resp_client, resp_code}, -1);
                end else begin
                    rsp_item_t e;
                    e = rsp_q.pop_front();
                    chk(int'(resp_client) == e.cl && int'(resp_code) == e.code, e.tag,
                        "response {client,code}", {resp_client, resp_code}, e.cl * 4 + e.code);
                end
                rsp_seen++;
            end
            if (evt != '0) begin
                if (evt_exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected event", evt, 0);
                end else begin
                    int c;
                    c = evt_exp_q.pop_front();
                    chk(evt == (N'(1) << c), "R10", "event vector", evt, 1 << c);
                end
                evt_seen++;
            end
        end
    end

    task automatic expect_evt(input int c);
        evt_exp_q.push_back(c);
        evt_pushed++;
    endtask

    task automatic wait_evts();
        while (evt_seen != evt_pushed) @(negedge clk);
    endtask

    task automatic issue(input logic op, input logic frc, input int c,
                         input logic [CNT_W-1:0] dl, input int code,
                         input bit busy_chk, input string tag);
        rsp_q.push_back('{cl: c, code: code, tag: tag});
        rsp_pushed++;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid    = 1'b1;
        req_op       = op;
        req_force    = frc;
        req_client   = 2'(c);
        req_deadline = dl;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (busy_chk) chk(req_ready == 1'b0, "R11", "ready during reload", req_ready, 0);
        while (rsp_seen != rsp_pushed) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string tag);
        int unsigned s;
        s = evt_seen;
        repeat (n) @(negedge clk);
        chk(evt_seen == s, tag, "no event in quiet window", evt_seen - s, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL R11 watchdog act=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] v;
        repeat (5) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(evt == '0, "R1", "no event after reset", evt, 0);
        chk(resp_valid == 1'b0, "R1", "no response after reset", resp_valid, 0);
        quiet(20, "R1");

        // R2/R3: first set takes the comparator; later and equal ones do not
        v = now_q + 300;
        issue(1'b0, 1'b0, 0, v, 0, 1'b1, "R2 R3 set owner");
        issue(1'b0, 1'b0, 1, now_q + 600, 0, 1'b0, "R2 later set");
        issue(1'b0, 1'b0, 2, v, 0, 1'b0, "R2 equal set keeps owner");
        expect_evt(0);
        wait_evts();
        // R8/R7: cancel the owner after its event; tied client 2 is past due
        expect_evt(2);
        issue(1'b1, 1'b0, 0, '0, 2, 1'b0, "R8 cancel owner after event");
        wait_evts();
        issue(1'b1, 1'b0, 3, '0, 3, 1'b0, "R8 non-owner cancel refused");
        issue(1'b1, 1'b0, 2, '0, 2, 1'b0, "R7 cancel fired client");
        issue(1'b1, 1'b0, 1, '0, 3, 1'b0, "R8 owner cancel before deadline refused");
        expect_evt(1);
        wait_evts();
        issue(1'b1, 1'b0, 1, '0, 2, 1'b0, "R6 last cancel");
        quiet(60, "R6");

        // R5: scan tie resolves to lowest index
        v = now_q + 400;
        issue(1'b0, 1'b0, 3, v, 0, 1'b0, "R5 set c3");
        issue(1'b0, 1'b0, 2, v, 0, 1'b0, "R5 set c2 tie");
        issue(1'b0, 1'b0, 1, v, 0, 1'b0, "R5 set c1 tie");
        issue(1'b1, 1'b1, 3, '0, 2, 1'b0, "R5 R9 forced cancel owner");
        expect_evt(1);
        wait_evts();
        expect_evt(2);
        issue(1'b1, 1'b0, 1, '0, 2, 1'b0, "R7 cancel c1");
        wait_evts();
        issue(1'b1, 1'b0, 2, '0, 2, 1'b0, "R6 cancel c2");
        quiet(30, "R6");

        // R4: deadlines already behind the counter
        issue(1'b0, 1'b0, 3, now_q - 100, 1, 1'b1, "R4 miss with no owner");
        quiet(40, "R4");
        issue(1'b0, 1'b0, 1, now_q + 500, 0, 1'b0, "R4 live owner");
        issue(1'b0, 1'b0, 0, now_q - 50, 1, 1'b1, "R4 past set undercuts owner");
        expect_evt(1);
        wait_evts();
        issue(1'b1, 1'b0, 1, '0, 2, 1'b0, "R4 cancel restored owner");

        // R9: forced cancel of a non-owner
        issue(1'b0, 1'b0, 0, now_q + 200, 0, 1'b0, "R9 set c0");
        issue(1'b0, 1'b0, 1, now_q + 400, 0, 1'b0, "R9 set c1");
        issue(1'b1, 1'b1, 1, '0, 2, 1'b0, "R9 forced cancel non-owner");
        expect_evt(0);
        wait_evts();
        issue(1'b1, 1'b0, 0, '0, 2, 1'b0, "R9 cancel c0");
        quiet(400, "R9");
        issue(1'b1, 1'b1, 3, '0, 2, 1'b0, "R8 forced cancel idle");

        // R2: owner moves its own deadline later; strictly earlier set takes over
        issue(1'b0, 1'b0, 0, now_q + 100, 0, 1'b0, "R2 set c0 early");
        issue(1'b0, 1'b0, 0, now_q + 600, 0, 1'b1, "R2 owner rearm later");
        quiet(300, "R2");
        expect_evt(0);
        wait_evts();
        issue(1'b1, 1'b0, 0, '0, 2, 1'b0, "R2 cancel c0");
        issue(1'b0, 1'b0, 2, now_q + 800, 0, 1'b0, "R2 set c2");
        issue(1'b0, 1'b0, 1, now_q + 300, 0, 1'b1, "R2 earlier set reloads");
        expect_evt(1);
        wait_evts();
        issue(1'b1, 1'b0, 1, '0, 2, 1'b0, "R2 cancel c1");
        expect_evt(2);
        wait_evts();
        issue(1'b1, 1'b0, 2, '0, 2, 1'b0, "R6 cancel c2");
        quiet(50, "R6");

        chk(rsp_q.size() == 0 && evt_exp_q.size() == 0, "R10", "scoreboard drained",
            rsp_q.size() + evt_exp_q.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule